// File: doc/BRIEF.md
# Multithreaded Commit Squash Controller

This block holds the per-thread squash bookkeeping of the commit stage in a multithreaded out-of-order core. Each hardware thread accepts three kinds of flush: a trap, which is held for a programmable number of cycles before it turns into a flush; an external context flush raised by the thread's architectural-state owner; and a mispredict or replay flush reported by the execute stage. Execute-stage flushes are filtered against the youngest sequence number the thread has inserted, so that a younger flush never overrides an older one already in progress.

For every accepted flush the block reports a flush pulse, a boundary sequence number and a restart address pair to the earlier pipeline stages. While the reorder buffer works through the squashed entries it keeps a "buffer still squashing" indication asserted. The reorder buffer itself is outside the block: it is seen only through an empty flag, a head sequence number and a done-squashing flag per thread. All outputs are registered and describe the clock edge just taken.

Top module: `squash_ctrl_mt`

## Requirements
- R1: After reset every thread reports state Idle (code 0) on `status_o`, and every flush, squashing, mispredict and error output is 0, with the sequence and address outputs at 0.
- R2: State codes on `status_o` are Idle=0, Running=1, Squashing=2, TrapPending=3. An insert (`ins_vld_i`) records `ins_seq_i` as the thread's youngest sequence number and moves an Idle thread to Running; a thread never returns to Idle.
- R3: An execute flush (`ex_sq_i`) is accepted only when the thread is not in TrapPending and `ex_seq_i` is less than or equal to the youngest recorded sequence number (unsigned, no wrap); an accepted flush pulses `squash_o` and `rob_sq_o` after that edge and puts the thread in Squashing. A rejected one changes no output.
- R4: The boundary of an execute flush is `ex_seq_i`, minus one when `ex_incl_i` is set; it appears on `done_seq_o` and becomes the youngest recorded sequence number.
- R5: An accepted execute flush drives `redir_pc_o`/`redir_npc_o` from `ex_pc_i`/`ex_npc_i` and copies `ex_misp_i` to `misp_o`; `misp_o` is 0 for every other cycle.
- R6: In Squashing, `rob_sq_o` is asserted after every edge at which `rob_done_i` is low; at an edge with `rob_done_i` high the thread moves to Running.
- R7: A context request (`ctx_req_i`) is held and served at the next edge as a flush-all: boundary `rob_head_i - 1`, or 0 when `rob_empty_i` is set; redirect from the last `pc_i`/`npc_i` captured by `pc_upd_i`; youngest recorded sequence cleared to 0; `misp_o` 0.
- R8: A trap request (`trap_req_i`) is taken only from Running; it puts the thread in TrapPending, and with `trap_lat_i` = L sampled at the request edge, a flush-all (as in R7) is reported after the edge L+2 edges after the request edge.
- R9: In TrapPending, execute flushes are ignored.
- R10: When a trap flush and a context flush are pending together, the trap one is served first and the context one at the following edge; `proto_err_o` pulses for one cycle, after the edge at which the trap one is served.
- R11: When a flush-all is served, an execute flush at the same edge is judged against the cleared youngest value (0); if accepted it wins the boundary, redirect and mispredict outputs.
- R12: Threads are independent: stimulus on one thread changes no output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_lat_i | input | LAT_W | Trap delay in cycles, sampled when a trap starts |
| ins_vld_i | input | NUM_THR | Instruction inserted, per thread |
| ins_seq_i | input | NUM_THR x SEQ_W | Sequence number of the inserted instruction |
| pc_upd_i | input | NUM_THR | Capture restart addresses, per thread |
| pc_i | input | NUM_THR x PC_W | Restart address to capture |
| npc_i | input | NUM_THR x PC_W | Following restart address to capture |
| trap_req_i | input | NUM_THR | Start a trap |
| ctx_req_i | input | NUM_THR | External context flush request |
| ex_sq_i | input | NUM_THR | Execute-stage flush request |
| ex_seq_i | input | NUM_THR x SEQ_W | Sequence number of the flushing instruction |
| ex_incl_i | input | NUM_THR | Flush includes the flushing instruction |
| ex_misp_i | input | NUM_THR | Flush is a branch mispredict |
| ex_pc_i | input | NUM_THR x PC_W | Execute-stage restart address |
| ex_npc_i | input | NUM_THR x PC_W | Execute-stage following restart address |
| rob_empty_i | input | NUM_THR | Reorder buffer holds no entry for the thread |
| rob_head_i | input | NUM_THR x SEQ_W | Sequence number at the buffer head |
| rob_done_i | input | NUM_THR | Buffer finished squashing |
| squash_o | output | NUM_THR | Flush pulse to earlier stages |
| rob_sq_o | output | NUM_THR | Buffer is squashing |
| done_seq_o | output | NUM_THR x SEQ_W | Boundary of the last flush |
| redir_pc_o | output | NUM_THR x PC_W | Restart address of the last flush |
| redir_npc_o | output | NUM_THR x PC_W | Following restart address of the last flush |
| misp_o | output | NUM_THR | Flush was a mispredict |
| status_o | output | NUM_THR x 2 | Thread state code |
| proto_err_o | output | NUM_THR | Trap and context flush were pending together |

## Verification
The bound checker watches, on every cycle, the local relations between ports: a flush always comes with the squashing indication, squashing stays up while the buffer is not done, a thread held in TrapPending emits no flush, the mispredict flag only rides on a flush, the error flag is a single pulse and no thread falls back to Idle. What only the bench can show is the arithmetic and ordering behind those outputs: the sequence-number filter and the minus-one boundary, the exact L+2 trap delay, the cleared youngest value after a flush-all racing an execute flush, trap-before-context ordering and per-thread isolation; a behavioural model of all threads is compared with every output on every clock, alongside directed scenarios and a long randomized run.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
   typedef enum logic [1:0] {
      TS_IDLE  = 2'd0,
      TS_RUN   = 2'd1,
      TS_ROBSQ = 2'd2,
      TS_TRAP  = 2'd3
   } thr_state_e;
endpackage

// File: rtl/sqc_trap_timer.sv
module sqc_trap_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] lat,
   output logic             busy,
   output logic             fire
);
   logic [LAT_W-1:0] cnt;

   assign fire = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= lat;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/sqc_ex_filter.sv
module sqc_ex_filter #(
   parameter int SEQ_W = 16
) (
   input  logic             req,
   input  logic             blocked,
   input  logic [SEQ_W-1:0] seq,
   input  logic             incl,
   input  logic [SEQ_W-1:0] youngest,
   output logic             accept,
   output logic [SEQ_W-1:0] bound
);
   assign accept = req && !blocked && (seq <= youngest);
   assign bound  = seq - {{(SEQ_W-1){1'b0}}, incl};
endmodule

// File: rtl/sqc_thread.sv
module sqc_thread
   import sqc_pkg::*;
#(
   parameter int SEQ_W = 16,
   parameter int PC_W  = 32,
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] trap_lat,
   input  logic             ins_vld,
   input  logic [SEQ_W-1:0] ins_seq,
   input  logic             pc_upd,
   input  logic [PC_W-1:0]  pc,
   input  logic [PC_W-1:0]  npc,
   input  logic             trap_req,
   input  logic             ctx_req,
   input  logic             ex_sq,
   input  logic [SEQ_W-1:0] ex_seq,
   input  logic             ex_incl,
   input  logic             ex_misp,
   input  logic [PC_W-1:0]  ex_pc,
   input  logic [PC_W-1:0]  ex_npc,
   input  logic             rob_empty,
   input  logic [SEQ_W-1:0] rob_head,
   input  logic             rob_done,
   output logic             squash,
   output logic             rob_sq,
   output logic [SEQ_W-1:0] done_seq,
   output logic [PC_W-1:0]  redir_pc,
   output logic [PC_W-1:0]  redir_npc,
   output logic             misp,
   output logic [1:0]       state,
   output logic             proto_err
);
   localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

   thr_state_e       st, st_a, st_b, st_c, st_n;
   logic [SEQ_W-1:0] young, young_b, young_n, sa_bnd, ex_bnd;
   logic [PC_W-1:0]  pc_sv, npc_sv;
   logic             trap_sq, tc_sq, sa, sa_trap, sa_tc, hold;
   logic             ex_ok, ins_ok, trap_go, tmr_busy, tmr_fire;

   // buffer squash progress is looked at before any new flush
   assign hold    = (st == TS_ROBSQ) && !rob_done;
   assign st_a    = (st == TS_ROBSQ && rob_done) ? TS_RUN : st;

   // flush-all sources: trap wins over context
   assign sa_trap = trap_sq;
   assign sa_tc   = tc_sq && !trap_sq;
   assign sa      = sa_trap || sa_tc;
   assign sa_bnd  = rob_empty ? '0 : rob_head - SEQ_ONE;
   assign st_b    = sa ? TS_ROBSQ : st_a;
   assign young_b = sa ? '0 : young;

   sqc_ex_filter #(.SEQ_W(SEQ_W)) u_filt (
      .req      (ex_sq),
      .blocked  (st_b == TS_TRAP),
      .seq      (ex_seq),
      .incl     (ex_incl),
      .youngest (young_b),
      .accept   (ex_ok),
      .bound    (ex_bnd)
   );

   assign ins_ok  = ins_vld && !sa && !ex_ok;
   assign st_c    = ex_ok ? TS_ROBSQ :
                    (ins_ok && st_b == TS_IDLE) ? TS_RUN : st_b;
   assign trap_go = trap_req && (st_c == TS_RUN) && !tmr_busy;
   assign st_n    = trap_go ? TS_TRAP : st_c;
   assign young_n = ex_ok ? ex_bnd : sa ? '0 : ins_ok ? ins_seq : young;

   sqc_trap_timer #(.LAT_W(LAT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (trap_go),
      .lat   (trap_lat),
      .busy  (tmr_busy),
      .fire  (tmr_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= TS_IDLE;
         young     <= '0;
         pc_sv     <= '0;
         npc_sv    <= '0;
         trap_sq   <= 1'b0;
         tc_sq     <= 1'b0;
         squash    <= 1'b0;
         rob_sq    <= 1'b0;
         misp      <= 1'b0;
         proto_err <= 1'b0;
         done_seq  <= '0;
         redir_pc  <= '0;
         redir_npc <= '0;
      end else begin
         st        <= st_n;
         young     <= young_n;
         trap_sq   <= tmr_fire || (trap_sq && !sa_trap);
         tc_sq     <= (tc_sq && !sa_tc) || ctx_req;
         squash    <= sa || ex_ok;
         rob_sq    <= sa || ex_ok || hold;
         misp      <= ex_ok && ex_misp;
         proto_err <= trap_sq && tc_sq;
         if (pc_upd) begin
            pc_sv  <= pc;
            npc_sv <= npc;
         end
         if (ex_ok) begin
            done_seq  <= ex_bnd;
            redir_pc  <= ex_pc;
            redir_npc <= ex_npc;
         end else if (sa) begin
            done_seq  <= sa_bnd;
            redir_pc  <= pc_sv;
            redir_npc <= npc_sv;
         end
      end
   end

   assign state = st;
endmodule

// File: rtl/squash_ctrl_mt.sv
module squash_ctrl_mt #(
   parameter int NUM_THR = 4,
   parameter int SEQ_W   = 16,
   parameter int PC_W    = 32,
   parameter int LAT_W   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LAT_W-1:0]              trap_lat_i,
   input  logic [NUM_THR-1:0]            ins_vld_i,
   input  logic [NUM_THR-1:0][SEQ_W-1:0] ins_seq_i,
   input  logic [NUM_THR-1:0]            pc_upd_i,
   input  logic [NUM_THR-1:0][PC_W-1:0]  pc_i,
   input  logic [NUM_THR-1:0][PC_W-1:0]  npc_i,
   input  logic [NUM_THR-1:0]            trap_req_i,
   input  logic [NUM_THR-1:0]            ctx_req_i,
   input  logic [NUM_THR-1:0]            ex_sq_i,
   input  logic [NUM_THR-1:0][SEQ_W-1:0] ex_seq_i,
   input  logic [NUM_THR-1:0]            ex_incl_i,
   input  logic [NUM_THR-1:0]            ex_misp_i,
   input  logic [NUM_THR-1:0][PC_W-1:0]  ex_pc_i,
   input  logic [NUM_THR-1:0][PC_W-1:0]  ex_npc_i,
   input  logic [NUM_THR-1:0]            rob_empty_i,
   input  logic [NUM_THR-1:0][SEQ_W-1:0] rob_head_i,
   input  logic [NUM_THR-1:0]            rob_done_i,
   output logic [NUM_THR-1:0]            squash_o,
   output logic [NUM_THR-1:0]            rob_sq_o,
   output logic [NUM_THR-1:0][SEQ_W-1:0] done_seq_o,
   output logic [NUM_THR-1:0][PC_W-1:0]  redir_pc_o,
   output logic [NUM_THR-1:0][PC_W-1:0]  redir_npc_o,
   output logic [NUM_THR-1:0]            misp_o,
   output logic [NUM_THR-1:0][1:0]       status_o,
   output logic [NUM_THR-1:0]            proto_err_o
);
   if (NUM_THR < 1 || NUM_THR > 4) begin : g_bad_thr
      $error("squash_ctrl_mt: NUM_THR must be 1..4");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("squash_ctrl_mt: SEQ_W must be at least 2");
   end
   if (PC_W < 1 || LAT_W < 1) begin : g_bad_w
      $error("squash_ctrl_mt: PC_W and LAT_W must be positive");
   end

   for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
      sqc_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_thr (
         .clk       (clk),
         .rst_n     (rst_n),
         .trap_lat  (trap_lat_i),
         .ins_vld   (ins_vld_i[g]),
         .ins_seq   (ins_seq_i[g]),
         .pc_upd    (pc_upd_i[g]),
         .pc        (pc_i[g]),
         .npc       (npc_i[g]),
         .trap_req  (trap_req_i[g]),
         .ctx_req   (ctx_req_i[g]),
         .ex_sq     (ex_sq_i[g]),
         .ex_seq    (ex_seq_i[g]),
         .ex_incl   (ex_incl_i[g]),
         .ex_misp   (ex_misp_i[g]),
         .ex_pc     (ex_pc_i[g]),
         .ex_npc    (ex_npc_i[g]),
         .rob_empty (rob_empty_i[g]),
         .rob_head  (rob_head_i[g]),
         .rob_done  (rob_done_i[g]),
         .squash    (squash_o[g]),
         .rob_sq    (rob_sq_o[g]),
         .done_seq  (done_seq_o[g]),
         .redir_pc  (redir_pc_o[g]),
         .redir_npc (redir_npc_o[g]),
         .misp      (misp_o[g]),
         .state     (status_o[g]),
         .proto_err (proto_err_o[g])
      );
   end
endmodule

// File: rtl/sqc_checker.sv
module sqc_checker #(
   parameter int NUM_THR = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_THR-1:0]      squash,
   input logic [NUM_THR-1:0]      rob_sq,
   input logic [NUM_THR-1:0]      misp,
   input logic [NUM_THR-1:0]      perr,
   input logic [NUM_THR-1:0]      rob_done,
   input logic [NUM_THR-1:0][1:0] status
);
   for (genvar i = 0; i < NUM_THR; i++) begin : g_chk
      assert_flush_marks_squashing_R3: assert property (@(posedge clk) disable iff (!rst_n)
         squash[i] |-> rob_sq[i]);
      assert_hold_while_not_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] == 2'd2 && !rob_done[i]) |=> rob_sq[i]);
      assert_leave_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] == 2'd2 && rob_done[i]) |=> (status[i] != 2'd2 || rob_sq[i]));
      assert_trap_blocks_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] == 2'd3) |=> (status[i] != 2'd3 || !squash[i]));
      assert_misp_rides_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
         misp[i] |-> squash[i]);
      assert_err_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
         perr[i] |=> !perr[i]);
      assert_err_with_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
         perr[i] |-> squash[i]);
      assert_no_return_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] != 2'd0) |=> (status[i] != 2'd0));
   end
endmodule

bind squash_ctrl_mt sqc_checker #(.NUM_THR(NUM_THR)) u_sqc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .squash   (squash_o),
   .rob_sq   (rob_sq_o),
   .misp     (misp_o),
   .perr     (proto_err_o),
   .rob_done (rob_done_i),
   .status   (status_o)
);

// File: tb/sim_squash_ctrl_mt.sv
module sim_squash_ctrl_mt;
   localparam int NT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [7:0]          trap_lat;
   logic [NT-1:0]       ins_vld, pc_upd, trap_req, ctx_req, ex_sq, ex_incl, ex_misp;
   logic [NT-1:0]       rob_empty, rob_done;
   logic [NT-1:0][15:0] ins_seq, ex_seq, rob_head;
   logic [NT-1:0][31:0] pc, npc, ex_pc, ex_npc;
   logic [NT-1:0]       squash_o, rob_sq_o, misp_o, proto_err_o;
   logic [NT-1:0][15:0] done_seq_o;
   logic [NT-1:0][31:0] redir_pc_o, redir_npc_o;
   logic [NT-1:0][1:0]  status_o;

   squash_ctrl_mt #(.NUM_THR(NT), .SEQ_W(16), .PC_W(32), .LAT_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .trap_lat_i(trap_lat),
      .ins_vld_i(ins_vld), .ins_seq_i(ins_seq),
      .pc_upd_i(pc_upd), .pc_i(pc), .npc_i(npc),
      .trap_req_i(trap_req), .ctx_req_i(ctx_req),
      .ex_sq_i(ex_sq), .ex_seq_i(ex_seq), .ex_incl_i(ex_incl), .ex_misp_i(ex_misp),
      .ex_pc_i(ex_pc), .ex_npc_i(ex_npc),
      .rob_empty_i(rob_empty), .rob_head_i(rob_head), .rob_done_i(rob_done),
      .squash_o(squash_o), .rob_sq_o(rob_sq_o), .done_seq_o(done_seq_o),
      .redir_pc_o(redir_pc_o), .redir_npc_o(redir_npc_o), .misp_o(misp_o),
      .status_o(status_o), .proto_err_o(proto_err_o));

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string rq, input string what, input int thr,
                      input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s thr%0d %s: actual %0h expected %0h", rq, thr, what, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int           m_st   [NT];
   int           m_tcnt [NT];
   logic [15:0]  m_young[NT];
   logic [31:0]  m_pc[NT], m_npc[NT];
   bit           m_tsq[NT], m_tcq[NT];
   bit           e_sq[NT], e_rsq[NT], e_misp[NT], e_err[NT];
   logic [15:0]  e_done[NT];
   logic [31:0]  e_rpc[NT], e_rnpc[NT];
   bit           model_live = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_tcnt[t] = -1; m_young[t] = 0; m_pc[t] = 0; m_npc[t] = 0;
            m_tsq[t] = 0; m_tcq[t] = 0; e_sq[t] = 0; e_rsq[t] = 0; e_misp[t] = 0;
            e_err[t] = 0; e_done[t] = 0; e_rpc[t] = 0; e_rnpc[t] = 0;
         end
         model_live = 1'b1;
      end else begin
         for (int t = 0; t < NT; t++) begin : mdl
            int s;
            bit hold, all, exok, insok, go, fire, old_t, old_c;
            logic [15:0] y, bnd, hb;
            old_t = m_tsq[t]; old_c = m_tcq[t];
            hold  = (m_st[t] == 2) && !rob_done[t];
            s     = (m_st[t] == 2 && rob_done[t]) ? 1 : m_st[t];
            all   = old_t || old_c;
            hb    = rob_empty[t] ? 16'd0 : 16'(rob_head[t] - 16'd1);
            y     = all ? 16'd0 : m_young[t];
            if (all) s = 2;
            bnd   = 16'(ex_seq[t] - {15'd0, ex_incl[t]});
            exok  = ex_sq[t] && (s != 3) && (ex_seq[t] <= y);
            insok = ins_vld[t] && !all && !exok;
            if (exok) s = 2;
            else if (insok && s == 0) s = 1;
            go    = trap_req[t] && (s == 1) && (m_tcnt[t] < 0);
            if (go) s = 3;
            fire  = (m_tcnt[t] == 0);
            e_err[t]  = old_t && old_c;
            e_sq[t]   = all || exok;
            e_rsq[t]  = all || exok || hold;
            e_misp[t] = exok && ex_misp[t];
            if (exok) begin
               e_done[t] = bnd; e_rpc[t] = ex_pc[t]; e_rnpc[t] = ex_npc[t];
            end else if (all) begin
               e_done[t] = hb; e_rpc[t] = m_pc[t]; e_rnpc[t] = m_npc[t];
            end
            if (pc_upd[t]) begin m_pc[t] = pc[t]; m_npc[t] = npc[t]; end
            if (exok) m_young[t] = bnd;
            else if (all) m_young[t] = 16'd0;
            else if (insok) m_young[t] = ins_seq[t];
            m_tsq[t] = fire;
            m_tcq[t] = (old_c && old_t) || ctx_req[t];
            if (go) m_tcnt[t] = int'(trap_lat);
            else if (fire) m_tcnt[t] = -1;
            else if (m_tcnt[t] > 0) m_tcnt[t] = m_tcnt[t] - 1;
            m_st[t] = s;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_live && !finished) begin
         for (int t = 0; t < NT; t++) begin
            chk("R2", "status", t, 64'(status_o[t]), 64'(m_st[t]));
            chk("R3", "squash", t, 64'(squash_o[t]), 64'(e_sq[t]));
            chk("R6", "rob_sq", t, 64'(rob_sq_o[t]), 64'(e_rsq[t]));
            chk("R4", "done_seq", t, 64'(done_seq_o[t]), 64'(e_done[t]));
            chk("R5", "redir_pc", t, 64'(redir_pc_o[t]), 64'(e_rpc[t]));
            chk("R5", "redir_npc", t, 64'(redir_npc_o[t]), 64'(e_rnpc[t]));
            chk("R5", "misp", t, 64'(misp_o[t]), 64'(e_misp[t]));
            chk("R10", "proto_err", t, 64'(proto_err_o[t]), 64'(e_err[t]));
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic clr();
      ins_vld = '0; pc_upd = '0; trap_req = '0; ctx_req = '0;
      ex_sq = '0; ex_incl = '0; ex_misp = '0;
   endtask

   task automatic step();
      tick();
      clr();
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      clr();
      trap_lat = 8'd3;
      ins_seq = '0; ex_seq = '0; pc = '0; npc = '0; ex_pc = '0; ex_npc = '0;
      rob_empty = '0; rob_done = '1;
      for (int t = 0; t < NT; t++) rob_head[t] = 16'd50;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;

      // R1: reset state
      for (int t = 0; t < NT; t++) begin
         chk("R1", "status", t, 64'(status_o[t]), 64'd0);
         chk("R1", "squash", t, 64'(squash_o[t]), 64'd0);
         chk("R1", "done_seq", t, 64'(done_seq_o[t]), 64'd0);
         chk("R1", "proto_err", t, 64'(proto_err_o[t]), 64'd0);
      end

      // R2: insert moves Idle to Running
      ins_vld[0] = 1; ins_seq[0] = 16'd20; step();
      chk("R2", "status after insert", 0, 64'(status_o[0]), 64'd1);

      // R3: younger flush is stale
      ex_sq[0] = 1; ex_seq[0] = 16'd25; step();
      chk("R3", "stale flush", 0, 64'(squash_o[0]), 64'd0);

      // R3 R4 R5: accepted flush including the instruction
      rob_done[0] = 0;
      ex_sq[0] = 1; ex_seq[0] = 16'd10; ex_incl[0] = 1; ex_misp[0] = 1;
      ex_pc[0] = 32'h100; ex_npc[0] = 32'h104; step();
      chk("R3", "accepted flush", 0, 64'(squash_o[0]), 64'd1);
      chk("R4", "boundary minus one", 0, 64'(done_seq_o[0]), 64'd9);
      chk("R5", "redir pc", 0, 64'(redir_pc_o[0]), 64'h100);
      chk("R5", "misp", 0, 64'(misp_o[0]), 64'd1);
      step();
      chk("R6", "rob_sq held", 0, 64'(rob_sq_o[0]), 64'd1);
      chk("R6", "flush pulse ends", 0, 64'(squash_o[0]), 64'd0);
      step();
      chk("R6", "still squashing", 0, 64'(status_o[0]), 64'd2);
      rob_done[0] = 1; step();
      chk("R6", "done to running", 0, 64'(status_o[0]), 64'd1);
      chk("R6", "rob_sq released", 0, 64'(rob_sq_o[0]), 64'd0);

      // R4: youngest now equals the boundary 9
      ex_sq[0] = 1; ex_seq[0] = 16'd10; step();
      chk("R4", "beyond new youngest", 0, 64'(squash_o[0]), 64'd0);
      ex_sq[0] = 1; ex_seq[0] = 16'd9; step();
      chk("R4", "at youngest", 0, 64'(done_seq_o[0]), 64'd9);
      step();

      // R7: context flush-all
      pc_upd[0] = 1; pc[0] = 32'h200; npc[0] = 32'h204; step();
      ctx_req[0] = 1; step();
      chk("R7", "held one edge", 0, 64'(squash_o[0]), 64'd0);
      step();
      chk("R7", "flush-all", 0, 64'(squash_o[0]), 64'd1);
      chk("R7", "head minus one", 0, 64'(done_seq_o[0]), 64'd49);
      chk("R7", "saved pc", 0, 64'(redir_pc_o[0]), 64'h200);
      chk("R7", "saved npc", 0, 64'(redir_npc_o[0]), 64'h204);
      chk("R7", "no misp", 0, 64'(misp_o[0]), 64'd0);
      ex_sq[0] = 1; ex_seq[0] = 16'd5; step();
      chk("R7", "youngest cleared", 0, 64'(squash_o[0]), 64'd0);
      rob_empty[0] = 1; ctx_req[0] = 1; step(); step();
      chk("R7", "empty boundary", 0, 64'(done_seq_o[0]), 64'd0);
      rob_empty[0] = 0;

      // R11: flush-all racing an execute flush
      ctx_req[0] = 1; step();
      ex_sq[0] = 1; ex_seq[0] = 16'd3; ex_misp[0] = 1; step();
      chk("R11", "exec rejected", 0, 64'(done_seq_o[0]), 64'd49);
      chk("R11", "no misp", 0, 64'(misp_o[0]), 64'd0);
      ctx_req[0] = 1; step();
      ex_sq[0] = 1; ex_seq[0] = 16'd0; ex_misp[0] = 1; ex_pc[0] = 32'h300; step();
      chk("R11", "exec wins", 0, 64'(redir_pc_o[0]), 64'h300);
      chk("R11", "exec misp", 0, 64'(misp_o[0]), 64'd1);
      step();
      chk("R8", "running before trap", 0, 64'(status_o[0]), 64'd1);

      // R8 R9: trap with latency 3
      trap_lat = 8'd3; trap_req[0] = 1; step();
      chk("R8", "trap pending", 0, 64'(status_o[0]), 64'd3);
      for (int k = 1; k <= 5; k++) begin
         if (k == 1) begin ex_sq[0] = 1; ex_seq[0] = 16'd0; end
         step();
         chk("R8", "trap timing", 0, 64'(squash_o[0]), (k == 5) ? 64'd1 : 64'd0);
         if (k == 1) chk("R9", "exec ignored in trap", 0, 64'(status_o[0]), 64'd3);
      end
      chk("R8", "trap boundary", 0, 64'(done_seq_o[0]), 64'd49);
      rob_done[0] = 0; trap_req[0] = 1; step();
      chk("R8", "trap outside running", 0, 64'(status_o[0]), 64'd2);
      rob_done[0] = 1; step();

      // R10: trap and context pending together
      trap_lat = 8'd0; trap_req[0] = 1; step();
      ctx_req[0] = 1; step();
      chk("R10", "nothing yet", 0, 64'(squash_o[0]), 64'd0);
      step();
      chk("R10", "trap first", 0, 64'(done_seq_o[0]), 64'd49);
      chk("R10", "error pulse", 0, 64'(proto_err_o[0]), 64'd1);
      rob_head[0] = 16'd70; step();
      chk("R10", "context next", 0, 64'(done_seq_o[0]), 64'd69);
      chk("R10", "error ends", 0, 64'(proto_err_o[0]), 64'd0);
      rob_head[0] = 16'd50; step();

      // R12: thread isolation
      ins_vld[2] = 1; ins_seq[2] = 16'd100; step();
      ex_sq[2] = 1; ex_seq[2] = 16'd50; step();
      chk("R12", "only thread 2", 2, 64'(squash_o), 64'h4);
      chk("R12", "thread 0 untouched", 0, 64'(status_o[0]), 64'd1);

      // randomized run, checked by the model each clock
      for (int c = 0; c < 3000; c++) begin
         if (c % 200 == 0) trap_lat = 8'($urandom % 6);
         for (int t = 0; t < NT; t++) begin
            ins_vld[t]   = ($urandom % 4) == 0;
            ins_seq[t]   = 16'($urandom % 64);
            pc_upd[t]    = ($urandom % 5) == 0;
            pc[t]        = $urandom;
            npc[t]       = $urandom;
            trap_req[t]  = ($urandom % 20) == 0;
            ctx_req[t]   = ($urandom % 25) == 0;
            ex_sq[t]     = ($urandom % 6) == 0;
            ex_seq[t]    = 16'($urandom % 64);
            ex_incl[t]   = ($urandom % 2) == 0;
            ex_misp[t]   = ($urandom % 2) == 0;
            ex_pc[t]     = $urandom;
            ex_npc[t]    = $urandom;
            rob_empty[t] = ($urandom % 5) == 0;
            rob_head[t]  = 16'(1 + $urandom % 63);
            rob_done[t]  = ($urandom % 3) != 0;
         end
         tick();
      end
      clr();
      tick(); tick();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule